// File: doc/BRIEF.md
# Addressed Crosspoint Control Memory

This block is the digital control store behind a crosspoint switch array of 4 rows by 8 columns. It keeps one enable bit per crosspoint, 32 in all. A stored 1 closes the matching switch and a stored 0 opens it. A row address and a column address pick one cell. While both chip-select and strobe are high, that cell takes the value of a single data input. A master clear drives every cell to 0.

The control pins are treated as asynchronous. A chain of synchronizer flops on a fast system clock samples them before they reach the store. While the write window is open, the addressed cell follows the data input on every clock. It keeps the last value seen before the strobe drops. Several copies of the block can share the address, data and strobe lines and be told apart by chip-select alone.

The whole enable vector is presented in three forms. The first is a flat 32-bit vector. The second is a row-by-column matrix view of the same bits. The third is a per-column occupancy vector, which flags the columns that have at least one closed switch.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `clear` is high at a clock edge, all 32 bits of `sw_en` and all bits of `col_busy` are 0 after that edge.
- R2: The cell index is row*8 + column, where `row_addr[0]` is the row LSB and `col_addr[0]` is the column LSB. For example, row 0 with column 1 is bit 1, and row 3 with column 7 is bit 31.
- R3: A write changes only the addressed bit. The other 31 bits keep their values.
- R4: With `chip_sel` low, strobe pulses leave every bit unchanged. With `strobe` low, `chip_sel` and data leave every bit unchanged.
- R5: While the synchronized `chip_sel` and `strobe` are both high, the addressed bit takes the synchronized `wr_data` on every clock. After the strobe falls, the bit keeps the last value written.
- R6: `clear` overrides any write in progress and acts whatever the level of `chip_sel`. It takes effect on the first clock edge at which it is high.
- R7: `sw_mat[r][c]` always equals `sw_en[r*8+c]`.
- R8: `col_busy[c]` is the OR of `sw_en[r*8+c]` over all four rows r.
- R9: The control inputs pass through 2 synchronizer stages. A change in the inputs, set up before edge k, shows on `sw_en` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Master clear, active high, synchronous, also resets the synchronizers |
| chip_sel | input | 1 | Device select, active high, asynchronous |
| strobe | input | 1 | Write strobe, active high, asynchronous |
| wr_data | input | 1 | Value for the addressed cell |
| row_addr | input | 2 | Row address |
| col_addr | input | 3 | Column address |
| sw_en | output | 32 | Switch enables, bit row*8+column |
| sw_mat | output | 4x8 | Same enables viewed as [row][column] |
| col_busy | output | 8 | Per-column OR across rows |

## Verification
Each of the 32 addresses is written in turn after a clear. A single set bit at the expected index separates correct decoding and isolation from aliasing or neighbour disturbance. Strobe with chip-select low, and chip-select with strobe low, show that both qualifiers are required. Toggling data inside one long strobe window shows the follow-through behaviour. Dropping data together with the strobe shows which value is kept. A clear raised mid-strobe, and another with chip-select low, show the override. A one-shot write timed edge by edge pins the synchronizer latency. A behavioural reference compares all three output views on every clock.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_ROW_BITS    = 2;
  localparam int unsigned XPT_COL_BITS    = 3;
  localparam int unsigned XPT_SYNC_STAGES = 2;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (clear) stg[s] <= '0;
        else       stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (clear) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xpt_cell_store.sv
module xpt_cell_store #(
  parameter int unsigned ROW_BITS = 2,
  parameter int unsigned COL_BITS = 3
) (
  input  logic                                      clk,
  input  logic                                      clear,
  input  logic                                      wr_en,
  input  logic [ROW_BITS-1:0]                       wr_row,
  input  logic [COL_BITS-1:0]                       wr_col,
  input  logic                                      wr_din,
  output logic [(1<<ROW_BITS)*(1<<COL_BITS)-1:0]    cells
);
  localparam int unsigned ROWS  = 1 << ROW_BITS;
  localparam int unsigned COLS  = 1 << COL_BITS;
  localparam int unsigned CELLS = ROWS * COLS;

  logic [CELLS-1:0] hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign hit[r*COLS+c] = (wr_row == ROW_BITS'(r)) && (wr_col == COL_BITS'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      cells <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < CELLS; i++) begin
        if (hit[i]) cells[i] <= wr_din;
      end
    end
  end

  // R6: clear wins over any write
  assert_clear_wins_R6: assert property (@(posedge clk)
    clear |=> (cells == '0));

  // R3: at most one cell moves per clock
  assert_single_cell_R3: assert property (@(posedge clk) disable iff (clear)
    !$past(clear) |-> ($countones(cells ^ $past(cells)) <= 1));

  // R5: addressed cell takes the data of the previous clock
  assert_follow_data_R5: assert property (@(posedge clk) disable iff (clear)
    wr_en |=> (cells[{$past(wr_row), $past(wr_col)}] == $past(wr_din)));
endmodule

// File: rtl/xpt_col_or.sv
module xpt_col_or #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input  logic [ROWS*COLS-1:0] cells,
  output logic [COLS-1:0]      col_busy
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] colv;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign colv[r] = cells[r*COLS+c];
    end
    assign col_busy[c] = |colv;
  end
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int unsigned ROW_BITS    = xpt_pkg::XPT_ROW_BITS,
  parameter int unsigned COL_BITS    = xpt_pkg::XPT_COL_BITS,
  parameter int unsigned SYNC_STAGES = xpt_pkg::XPT_SYNC_STAGES
) (
  input  logic                                           clk,
  input  logic                                           clear,
  input  logic                                           chip_sel,
  input  logic                                           strobe,
  input  logic                                           wr_data,
  input  logic [ROW_BITS-1:0]                            row_addr,
  input  logic [COL_BITS-1:0]                            col_addr,
  output logic [(1<<ROW_BITS)*(1<<COL_BITS)-1:0]         sw_en,
  output logic [(1<<ROW_BITS)-1:0][(1<<COL_BITS)-1:0]    sw_mat,
  output logic [(1<<COL_BITS)-1:0]                       col_busy
);
  localparam int unsigned ROWS   = 1 << ROW_BITS;
  localparam int unsigned COLS   = 1 << COL_BITS;
  localparam int unsigned CTRL_W = 3 + ROW_BITS + COL_BITS;

  logic [CTRL_W-1:0]   ctrl_raw, ctrl_sync;
  logic                s_cs, s_stb, s_din;
  logic [ROW_BITS-1:0] s_row;
  logic [COL_BITS-1:0] s_col;
  logic                wr_en;

  assign ctrl_raw = {chip_sel, strobe, wr_data, row_addr, col_addr};

  xpt_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .clear (clear),
    .d     (ctrl_raw),
    .q     (ctrl_sync)
  );

  assign {s_cs, s_stb, s_din, s_row, s_col} = ctrl_sync;
  assign wr_en = s_cs & s_stb;

  xpt_cell_store #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_store (
    .clk    (clk),
    .clear  (clear),
    .wr_en  (wr_en),
    .wr_row (s_row),
    .wr_col (s_col),
    .wr_din (s_din),
    .cells  (sw_en)
  );

  assign sw_mat = sw_en;

  xpt_col_or #(.ROWS(ROWS), .COLS(COLS)) u_colv (
    .cells    (sw_en),
    .col_busy (col_busy)
  );

  // R4: without a synchronized select and strobe the store holds still
  assert_hold_unselected_R4: assert property (@(posedge clk) disable iff (clear)
    !(s_cs && s_stb) |=> $stable(sw_en));
endmodule

// File: tb/xpt_ctrl_mem_tb.sv
module xpt_ctrl_mem_tb;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int N    = ROWS * COLS;
  localparam int SYNC = 2;

  typedef struct packed {
    logic cs; logic stb; logic d; logic [1:0] r; logic [2:0] c;
  } snap_t;

  logic clk = 1'b0;
  logic clear = 1'b1, chip_sel = 1'b0, strobe = 1'b0, wr_data = 1'b0;
  logic [1:0] row_addr = '0;
  logic [2:0] col_addr = '0;
  logic [N-1:0] sw_en;
  logic [ROWS-1:0][COLS-1:0] sw_mat;
  logic [COLS-1:0] col_busy;

  int checks = 0, failures = 0;
  string tag = "R9";
  logic [N-1:0] model = '0;
  snap_t pipe[$];

  always #5 clk = ~clk;

  xpt_ctrl_mem u_dut (
    .clk(clk), .clear(clear), .chip_sel(chip_sel), .strobe(strobe),
    .wr_data(wr_data), .row_addr(row_addr), .col_addr(col_addr),
    .sw_en(sw_en), .sw_mat(sw_mat), .col_busy(col_busy)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, updated at each edge and compared shortly after
  always @(posedge clk) begin
    if (clear) begin
      model = '0;
      pipe.delete();
      for (int i = 0; i < SYNC; i++) pipe.push_back('0);
    end else begin
      snap_t s;
      s = pipe.pop_front();
      if (s.cs && s.stb) model[int'(s.r) * COLS + int'(s.c)] = s.d;
      pipe.push_back({chip_sel, strobe, wr_data, row_addr, col_addr});
    end
    #2;
    chk(tag, sw_en, model);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        chk("R7", N'(sw_mat[r][c]), N'(model[r*COLS+c]));
    for (int c = 0; c < COLS; c++) begin
      logic any;
      any = 1'b0;
      for (int r = 0; r < ROWS; r++) any |= model[r*COLS+c];
      chk("R8", N'(col_busy[c]), N'(any));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; cyc(1); clear = 1'b0; cyc(1);
  endtask

  task automatic pulse_write(int r, int c, logic d, logic cs);
    row_addr = 2'(r); col_addr = 3'(c); wr_data = d; chip_sel = cs;
    cyc(1); strobe = 1'b1;
    cyc(2); strobe = 1'b0;
    cyc(1); chip_sel = 1'b0;
    cyc(4);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    tag = "R1";
    chk("R1", sw_en, '0);
    chk("R1", N'(col_busy), '0);
    clear = 1'b0; cyc(1);

    // R9: latency through the synchronizers
    tag = "R9";
    chip_sel = 1'b1; strobe = 1'b1; wr_data = 1'b1; row_addr = 2'd2; col_addr = 3'd4;
    cyc(1); chk("R9", N'(sw_en[20]), N'(1'b0));
    cyc(1); chk("R9", N'(sw_en[20]), N'(1'b0));
    cyc(1); chk("R9", N'(sw_en[20]), N'(1'b1));
    strobe = 1'b0; cyc(1); chip_sel = 1'b0; cyc(4);
    do_clear();

    // R2 and R3: every address sets only its own bit
    tag = "R3";
    pulse_write(0, 1, 1'b1, 1'b1);
    chk("R2", sw_en, N'(1) << 1);
    do_clear();
    pulse_write(3, 7, 1'b1, 1'b1);
    chk("R2", sw_en, N'(1) << 31);
    for (int i = 0; i < N; i++) begin
      do_clear();
      pulse_write(i / COLS, i % COLS, 1'b1, 1'b1);
      chk("R3", sw_en, N'(1) << i);
    end
    // R3: cumulative pattern then clear one bit
    do_clear();
    pulse_write(1, 2, 1'b1, 1'b1);
    pulse_write(2, 5, 1'b1, 1'b1);
    pulse_write(0, 0, 1'b1, 1'b1);
    pulse_write(1, 2, 1'b0, 1'b1);
    chk("R3", sw_en, (N'(1) << 21) | N'(1));

    // R4: qualifiers
    tag = "R4";
    pulse_write(3, 3, 1'b1, 1'b0);
    chk("R4", sw_en, (N'(1) << 21) | N'(1));
    chip_sel = 1'b1; wr_data = 1'b1; row_addr = 2'd3; col_addr = 3'd6;
    cyc(6); chip_sel = 1'b0; cyc(4);
    chk("R4", sw_en, (N'(1) << 21) | N'(1));

    // R5: follow-through inside one strobe window
    tag = "R5";
    do_clear();
    chip_sel = 1'b1; row_addr = 2'd1; col_addr = 3'd3; wr_data = 1'b1;
    cyc(1); strobe = 1'b1;
    cyc(4); chk("R5", N'(sw_en[11]), N'(1'b1));
    wr_data = 1'b0;
    cyc(4); chk("R5", N'(sw_en[11]), N'(1'b0));
    wr_data = 1'b1;
    cyc(4); chk("R5", N'(sw_en[11]), N'(1'b1));
    strobe = 1'b0; wr_data = 1'b0;
    cyc(5); chk("R5", sw_en, N'(1) << 11);
    chip_sel = 1'b0; cyc(2);

    // R6: clear mid-strobe, and clear with select low
    tag = "R6";
    chip_sel = 1'b1; strobe = 1'b1; wr_data = 1'b1; row_addr = 2'd0; col_addr = 3'd5;
    cyc(4); chk("R6", sw_en, (N'(1) << 11) | (N'(1) << 5));
    clear = 1'b1; cyc(1);
    chk("R6", sw_en, '0);
    clear = 1'b0; strobe = 1'b0; cyc(1); chip_sel = 1'b0; cyc(4);
    pulse_write(2, 2, 1'b1, 1'b1);
    chip_sel = 1'b0;
    clear = 1'b1; cyc(1);
    chk("R6", sw_en, '0);
    chk("R1", N'(col_busy), '0);
    clear = 1'b0; cyc(3);

    finish_run();
  end
endmodule